// File: doc/BRIEF.md
# Parallel Printer Port Register Interface

This block sits on a simple synchronous register bus and gives a processor a byte-wide parallel printer interface through three consecutive port addresses. A processor write to the data address latches a character that is driven continuously onto the outgoing data pins. A write to the control address sets the handshake and control pins, such as the strobe that marks a character as ready to print. A read of the status address returns the printer condition lines: ready, paper out, on-line and error.

Each port has its own access rule under the shared address decode. The data port can be read and written, and a read returns the byte last written rather than the pin state. The status port can only be read, and writes to it are dropped. The control port is set by writes, and a read returns the four control bits that were written. The status lines arrive asynchronously, so each one passes through a flop synchronizer before the processor can see it.

Top module: `lpt_port_regs`

## Requirements
- R1: After synchronous reset the data register is 0x00, so `pd_o` is 0x00, and all four control outputs are 0, which holds the strobe inactive.
- R2: The data register at offset 0 captures `bus_wdata` on a clock edge only when `bus_wr` is high and `bus_addr` is 0. `pd_o` shows the new value after that edge. A write to any other offset leaves it unchanged.
- R3: A read at offset 0 returns the byte most recently written to the data register.
- R4: A read at offset 1 returns the status byte: bit 7 = not ready (busy), bit 5 = paper out, bit 4 = on-line, bit 3 = error, and bits 6, 2, 1 and 0 read as 1.
- R5: A change on a status input appears in a status read after the second rising clock edge and not after the first.
- R6: A write to offset 1 changes no register and no output.
- R7: A write at offset 2 stores `bus_wdata[3:0]`. Bit 0 drives `ctl_strobe_o`, bit 1 drives `ctl_autofeed_o`, bit 2 drives `ctl_init_o` and bit 3 drives `ctl_select_o`. A read at offset 2 returns these four bits in bits 3:0, with zeros above.
- R8: Offset 3 reads as 0x00, and a write to it has no effect.
- R9: `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R10: A read access with `bus_wr` low leaves every register unchanged, whatever `bus_wdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from held state) |
| pd_o | output | 8 | Character byte to the printer |
| ptr_ready_i | input | 1 | Printer ready to accept (asynchronous) |
| ptr_paper_out_i | input | 1 | Paper exhausted (asynchronous) |
| ptr_online_i | input | 1 | Printer selected / on-line (asynchronous) |
| ptr_fault_i | input | 1 | Printer error (asynchronous) |
| ctl_strobe_o | output | 1 | Data strobe, active high |
| ctl_autofeed_o | output | 1 | Automatic line feed request |
| ctl_init_o | output | 1 | Printer initialise request |
| ctl_select_o | output | 1 | Select-printer request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit offset and a two-stage status synchronizer. With two stages, the bench can observe the status latency one edge at a time. It reads the status after the first edge, where the old value must still show, and after the second, where the new value must show. With a 4-bit control field, it can check that bits written above that field never read back.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int DATA_W = 8;
    localparam int OFS_W  = 2;
    localparam int CTL_W  = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA    = 2'd0,
        OFS_STATUS  = 2'd1,
        OFS_CONTROL = 2'd2,
        OFS_SPARE   = 2'd3
    } ofs_e;

    // status bit positions
    localparam int ST_BUSY  = 7;
    localparam int ST_PAPER = 5;
    localparam int ST_ONL   = 4;
    localparam int ST_ERR   = 3;

    typedef struct packed {
        logic ready;
        logic paper_out;
        logic online;
        logic fault;
    } status_t;

    typedef struct packed {
        logic select;
        logic init;
        logic autofeed;
        logic strobe;
    } control_t;

    typedef struct packed {
        logic wr_data;
        logic wr_ctrl;
        logic rd_data;
        logic rd_status;
        logic rd_ctrl;
    } sel_t;

    function automatic logic [DATA_W-1:0] pack_status(status_t s);
        logic [DATA_W-1:0] b;
        b = '1;
        b[ST_BUSY]  = ~s.ready;
        b[ST_PAPER] = s.paper_out;
        b[ST_ONL]   = s.online;
        b[ST_ERR]   = s.fault;
        return b;
    endfunction

endpackage

// File: rtl/lpt_addr_decode.sv
module lpt_addr_decode
    import lpt_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             wr,
    input  logic             rd,
    output sel_t             sel
);
    always_comb begin
        sel = '0;
        unique case (ofs_e'(addr))
            OFS_DATA: begin
                sel.wr_data = wr;
                sel.rd_data = rd;
            end
            OFS_STATUS: begin
                sel.rd_status = rd;
            end
            OFS_CONTROL: begin
                sel.wr_ctrl = wr;
                sel.rd_ctrl = rd;
            end
            OFS_SPARE: begin
                sel = '0;
            end
            default: sel = '0;
        endcase
    end

    always_comb begin
        a_r10_onehot_sel: assert ($onehot0({sel.rd_data, sel.rd_status, sel.rd_ctrl}));
    end
endmodule

// File: rtl/lpt_hold_reg.sv
module lpt_hold_reg #(
    parameter int          W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST;
        else if (we) q <= d;
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/lpt_sync_chain.sv
module lpt_sync_chain #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[k] <= '0;
            else     stage[k] <= stage[k-1];
        end
        a_r5_shift: assert property (@(posedge clk) disable iff (rst)
            prev_run |-> (stage[k] == $past(stage[k-1])));
    end

    assign q = stage[STAGES-1];

    // records whether the previous edge was outside reset
    logic prev_run;
    always_ff @(posedge clk) begin
        if (rst) prev_run <= 1'b0;
        else     prev_run <= 1'b1;
    end

    a_r5_first: assert property (@(posedge clk) disable iff (rst)
        prev_run |-> (stage[0] == $past(d)));
endmodule

// File: rtl/lpt_port_regs.sv
module lpt_port_regs
    import lpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pd_o,
    input  logic              ptr_ready_i,
    input  logic              ptr_paper_out_i,
    input  logic              ptr_online_i,
    input  logic              ptr_fault_i,
    output logic              ctl_strobe_o,
    output logic              ctl_autofeed_o,
    output logic              ctl_init_o,
    output logic              ctl_select_o
);
    localparam int ST_W = $bits(status_t);

    sel_t     sel;
    status_t  st_raw, st_sync;
    control_t ctl_q;
    logic [DATA_W-1:0] data_q;

    lpt_addr_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .sel  (sel)
    );

    lpt_hold_reg #(.W(DATA_W), .RST('0)) u_data (
        .clk (clk),
        .rst (rst),
        .we  (sel.wr_data),
        .d   (bus_wdata),
        .q   (data_q)
    );

    lpt_hold_reg #(.W(CTL_W), .RST('0)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .we  (sel.wr_ctrl),
        .d   (bus_wdata[CTL_W-1:0]),
        .q   (ctl_q)
    );

    assign st_raw = '{ready: ptr_ready_i, paper_out: ptr_paper_out_i,
                      online: ptr_online_i, fault: ptr_fault_i};

    lpt_sync_chain #(.W(ST_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (st_raw),
        .q   (st_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel.rd_data)   bus_rdata = data_q;
        if (sel.rd_status) bus_rdata = pack_status(st_sync);
        if (sel.rd_ctrl)   bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
    end

    assign pd_o           = data_q;
    assign ctl_strobe_o   = ctl_q.strobe;
    assign ctl_autofeed_o = ctl_q.autofeed;
    assign ctl_init_o     = ctl_q.init;
    assign ctl_select_o   = ctl_q.select;

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
    a_r8_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_SPARE) |-> (bus_rdata == '0));
    a_r6_status_wr_noeffect: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_STATUS) |=>
            ($stable(pd_o) && $stable({ctl_select_o, ctl_init_o, ctl_autofeed_o, ctl_strobe_o})));
    a_r3_data_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_DATA) |-> (bus_rdata == pd_o));
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (pd_o == '0 && !ctl_strobe_o));
endmodule

// File: tb/lpt_port_regs_tb_top.sv
module lpt_port_regs_tb_top;
    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] bus_addr = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata, pd_o;
    logic       rdy = 0, pout = 0, onl = 0, flt = 0;
    logic       stb, afd, ini, sel;

    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lpt_port_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_o(pd_o),
        .ptr_ready_i(rdy), .ptr_paper_out_i(pout), .ptr_online_i(onl), .ptr_fault_i(flt),
        .ctl_strobe_o(stb), .ctl_autofeed_o(afd), .ctl_init_o(ini), .ctl_select_o(sel)
    );

    function automatic logic [7:0] exp_status(logic r, logic p, logic o, logic f);
        return {~r, 1'b1, p, o, f, 3'b111};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pd_o", pd_o, 8'h00);
        chk("R1 ctl", {4'h0, sel, ini, afd, stb}, 8'h00);
        bus_read(2'd0, v); chk("R1 data read", v, 8'h00);
        bus_read(2'd2, v); chk("R1 ctrl read", v, 8'h00);
        bus_read(2'd1, v); chk("R4 reset status", v, exp_status(0, 0, 0, 0));
    endtask

    task automatic t_data();
        logic [7:0] v;
        bus_write(2'd0, 8'hA5);
        chk("R2 pd_o", pd_o, 8'hA5);
        bus_read(2'd0, v); chk("R3 readback", v, 8'hA5);
        bus_write(2'd0, 8'h3C);
        bus_read(2'd0, v); chk("R3 readback2", v, 8'h3C);
        bus_write(2'd2, 8'h00);
        chk("R2 other offset", pd_o, 8'h3C);
    endtask

    task automatic t_read_only_access();
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'hFF; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        chk("R10 data after read", pd_o, 8'h3C);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'hFF; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        chk("R10 ctrl after read", {4'h0, sel, ini, afd, stb}, 8'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        bus_write(2'd2, 8'hF5);
        chk("R7 outs", {4'h0, sel, ini, afd, stb}, 8'h05);
        bus_read(2'd2, v); chk("R7 readback", v, 8'h05);
        bus_write(2'd2, 8'h0A);
        chk("R7 outs2", {4'h0, sel, ini, afd, stb}, 8'h0A);
        bus_read(2'd2, v); chk("R7 readback2", v, 8'h0A);
    endtask

    task automatic t_status();
        logic [7:0] v;
        @(negedge clk);
        rdy = 1; pout = 0; onl = 1; flt = 0;
        @(negedge clk);
        bus_read(2'd1, v); chk("R5 one edge old", v, exp_status(0, 0, 0, 0));
        @(negedge clk);
        bus_read(2'd1, v); chk("R5 two edges new", v, exp_status(1, 0, 1, 0));
        chk("R4 layout 57", v, 8'h57);
        rdy = 0; pout = 1; onl = 0; flt = 1;
        repeat (2) @(negedge clk);
        bus_read(2'd1, v); chk("R4 layout EF", v, 8'hEF);
    endtask

    task automatic t_status_write();
        logic [7:0] v;
        bus_write(2'd1, 8'h00);
        chk("R6 pd_o", pd_o, 8'h3C);
        chk("R6 ctl", {4'h0, sel, ini, afd, stb}, 8'h0A);
        bus_read(2'd1, v); chk("R6 status", v, 8'hEF);
    endtask

    task automatic t_spare();
        logic [7:0] v;
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, v); chk("R8 spare read", v, 8'h00);
        chk("R8 pd_o", pd_o, 8'h3C);
        chk("R8 ctl", {4'h0, sel, ini, afd, stb}, 8'h0A);
    endtask

    task automatic t_idle();
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 0;
        #1 chk("R9 idle rdata", bus_rdata, 8'h00);
        bus_addr = 2'd2;
        #1 chk("R9 idle rdata ctrl", bus_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_data();
        t_read_only_access();
        t_ctrl();
        t_status();
        t_status_write();
        t_spare();
        t_idle();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule